// File: doc/BRIEF.md
# Peripheral Interrupt Level Router

This block takes a wide set of level-sensitive peripheral interrupt lines and steers each one onto one of eight core priority levels, numbered 7 to 14. Each source owns a 4-bit routing field. A field value of 0 to 7 selects core level value + 7. Any larger value leaves the source unrouted. A per-source enable bit gates the request before it is routed. Every core level raises its request when at least one enabled, asserted source is routed to it.

Because many peripherals may share one core level, the block also keeps a registered bitset for each level that lists the sources contributing to it. A dispatcher can select a level on `lvl_sel` and read that bitset on `lvl_vec` to find out which peripherals need service. A simple register port holds the routing fields and the enable mask, and reports the raw, unmasked source lines. The register port, the source lines and the level outputs are plain control and status signals with no back-pressure: a write takes effect at the clock edge where `reg_wen` is sampled high, and read data returns one cycle after `reg_ren`.

Top module: `irq_level_router`

## Requirements
- R1: After reset, sources 19, 20, 94 and 95 hold routing field 5 (core level 12). Every other source holds 0xF (unrouted). All enable bits are 1. `level_req` and every level bitset are 0.
- R2: Source s has its routing field in word address s/8, at bits [4*(s%8)+3 : 4*(s%8)]. Words 0 to 11 can be written and read back.
- R3: A field value v in 0..7 routes the source to core level v+7, which is reported on `level_req[v]`. A source never contributes to more than one level.
- R4: `level_req[v]` is the OR of every enabled, asserted source routed to level v+7. It stays high while any one of them remains asserted.
- R5: A source whose field holds 8..15 drives no level and appears in no bitset. Its field still reads back as written.
- R6: Enable bit s lives at word address 16 + s/32, bit s%32. A cleared bit blocks the source from every level and bitset. Raw status (words 20 to 22, same bit layout) still shows the line.
- R7: `lvl_vec` returns the registered bitset of level `lvl_sel`+7. Bit s is set only for an enabled, asserted source routed there.
- R8: `level_req` and the bitsets are registered. A change on `src_irq` or in the configuration shows one clock edge after it is sampled, and not before.
- R9: Writes to the raw status words and to unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R10: `reg_rdata` updates on the clock edge where `reg_ren` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 96 | Level-sensitive peripheral request lines |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| lvl_sel | input | 3 | Core level select for the bitset read (level = value + 7) |
| lvl_vec | output | 96 | Contributing sources of the selected level |
| level_req | output | 8 | Request per core level, bit v = level v+7 |

## Verification
A corrupted routing field shows up on the first edge after the source asserts. The request appears on the wrong `level_req` bit, or on none, and the source's bit moves to another level's bitset. Readback of the field word exposes the same fault on the next read. A stuck enable bit or a broken OR tree shows up as a request that stays low while its source is active. It can also show up as a request that stays high for one edge after the last sharing source drops. The bench therefore compares all eight bitsets against a model after every stimulus step.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned FIELD_W      = 4;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned FLDS_PER_WRD = WORD_W / FIELD_W;
  localparam logic [FIELD_W-1:0] FLD_UNROUTED = '1;
  localparam logic [FIELD_W-1:0] FLD_RST_HOT  = FIELD_W'(5);

  // Reset routing value of one source: the GPIO-group lines start on level 12.
  function automatic logic [FIELD_W-1:0] reset_field(input int unsigned s);
    if (s == 19 || s == 20 || s == 94 || s == 95) return FLD_RST_HOT;
    return FLD_UNROUTED;
  endfunction
endpackage

// File: rtl/irq_cfg_store.sv
module irq_cfg_store
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 96,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MASK_BASE = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wen,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [NUM_SRC-1:0][FIELD_W-1:0]   fld_q,
  output logic [NUM_SRC-1:0]                en_q
);
  localparam int unsigned N_FLD_WRD  = NUM_SRC / FLDS_PER_WRD;
  localparam int unsigned N_MASK_WRD = NUM_SRC / WORD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) fld_q[s] <= reset_field(s);
      en_q <= '1;
    end else if (wen) begin
      for (int w = 0; w < N_FLD_WRD; w++) begin
        if (addr == ADDR_W'(w)) begin
          for (int k = 0; k < FLDS_PER_WRD; k++)
            fld_q[w*FLDS_PER_WRD + k] <= wdata[k*FIELD_W +: FIELD_W];
        end
      end
      for (int m = 0; m < N_MASK_WRD; m++) begin
        if (addr == ADDR_W'(MASK_BASE + m)) en_q[m*WORD_W +: WORD_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned NUM_LVL = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               src_irq,
  input  logic [NUM_SRC-1:0]               en,
  input  logic [NUM_SRC-1:0][FIELD_W-1:0]  fld,
  output logic [NUM_LVL-1:0][NUM_SRC-1:0]  bits_q,
  output logic [NUM_LVL-1:0]               req_q
);
  logic [NUM_SRC-1:0] gated;
  assign gated = src_irq & en;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] hit;
    // A field of NUM_LVL or above never equals any level index: unrouted.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = gated[s] && (fld[s] == FIELD_W'(l));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[l] <= '0;
        req_q[l]  <= 1'b0;
      end else begin
        bits_q[l] <= hit;
        req_q[l]  <= |hit;
      end
    end
  end
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 96,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MASK_BASE = 16,
  parameter int unsigned STAT_BASE = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ren,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_SRC-1:0][FIELD_W-1:0]  fld,
  input  logic [NUM_SRC-1:0]               en,
  input  logic [NUM_SRC-1:0]               raw,
  output logic [WORD_W-1:0]                rdata_q
);
  localparam int unsigned N_FLD_WRD  = NUM_SRC / FLDS_PER_WRD;
  localparam int unsigned N_MASK_WRD = NUM_SRC / WORD_W;

  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    for (int w = 0; w < N_FLD_WRD; w++) begin
      if (addr == ADDR_W'(w)) begin
        for (int k = 0; k < FLDS_PER_WRD; k++)
          word[k*FIELD_W +: FIELD_W] = fld[w*FLDS_PER_WRD + k];
      end
    end
    for (int m = 0; m < N_MASK_WRD; m++) begin
      if (addr == ADDR_W'(MASK_BASE + m)) word = en[m*WORD_W +: WORD_W];
      if (addr == ADDR_W'(STAT_BASE + m)) word = raw[m*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (ren) rdata_q <= word;
  end
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 96,
  parameter int unsigned NUM_LVL   = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned MASK_BASE = 16,
  parameter int unsigned STAT_BASE = 20,
  localparam int unsigned SEL_W    = $clog2(NUM_LVL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_irq,
  input  logic                 reg_wen,
  input  logic                 reg_ren,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic [SEL_W-1:0]     lvl_sel,
  output logic [NUM_SRC-1:0]   lvl_vec,
  output logic [NUM_LVL-1:0]   level_req
);
  logic [NUM_SRC-1:0][FIELD_W-1:0] fld;
  logic [NUM_SRC-1:0]              en;
  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_bits;

  irq_cfg_store #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .fld_q(fld), .en_q(en)
  );

  irq_route_matrix #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_route (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .en(en), .fld(fld),
    .bits_q(lvl_bits), .req_q(level_req)
  );

  irq_reg_read #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE),
                 .STAT_BASE(STAT_BASE)) u_rd (
    .clk(clk), .rst_n(rst_n), .ren(reg_ren), .addr(reg_addr),
    .fld(fld), .en(en), .raw(src_irq), .rdata_q(reg_rdata)
  );

  assign lvl_vec = lvl_bits[lvl_sel];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned NUM_LVL = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_SRC-1:0]               src_irq,
  input logic [NUM_SRC-1:0]               en,
  input logic [NUM_SRC-1:0][FIELD_W-1:0]  fld,
  input logic [NUM_LVL-1:0][NUM_SRC-1:0]  lvl_bits,
  input logic [NUM_LVL-1:0]               level_req
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // Checker-side view of what each level should carry after the next edge.
  logic [NUM_LVL-1:0] want;
  always_comb begin
    want = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_irq[s] && en[s] && fld[s] < FIELD_W'(NUM_LVL)) want[fld[s][2:0]] = 1'b1;
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_l
    AST_LEVEL_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> level_req[l] == $past(want[l])); // R8
    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      level_req[l] |-> (lvl_bits[l] != '0)); // R4
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
    logic [NUM_LVL-1:0] col;
    always_comb for (int l = 0; l < NUM_LVL; l++) col[l] = lvl_bits[l][s];
    AST_SINGLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col)); // R3
    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(fld[s] >= FIELD_W'(NUM_LVL)) |-> col == '0); // R5
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(en[s]) |-> col == '0); // R6
    AST_BIT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && (col != '0) |-> $past(src_irq[s])); // R7
  end
endmodule

bind irq_level_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .en(en), .fld(fld),
  .lvl_bits(lvl_bits), .level_req(level_req)
);

// File: tb/irq_level_router_tb.sv
module irq_level_router_tb_top;
  localparam int NS = 96;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_irq = '0;
  logic          reg_wen = 1'b0;
  logic          reg_ren = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [2:0]    lvl_sel = '0;
  logic [NS-1:0] lvl_vec;
  logic [NL-1:0] level_req;

  always #10 clk = ~clk; // 50 MHz

  irq_level_router dut_i (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_sel(lvl_sel), .lvl_vec(lvl_vec), .level_req(level_req)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Model state, built from the requirements.
  logic [3:0] m_fld [NS];
  logic       m_en  [NS];

  task automatic chk(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_bits(input int l);
    logic [NS-1:0] v = '0;
    for (int s = 0; s < NS; s++)
      if (src_irq[s] && m_en[s] && m_fld[s] == 4'(l)) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] w = '0;
    if (a < 12) for (int k = 0; k < 8; k++) w[k*4 +: 4] = m_fld[a*8 + k];
    else if (a >= 16 && a < 19) for (int b = 0; b < 32; b++) w[b] = m_en[(a-16)*32 + b];
    else if (a >= 20 && a < 23) w = src_irq[(a-20)*32 +: 32];
    return w;
  endfunction

  // Called just after a falling edge: compare every level against the model.
  task automatic cmp_all(input string req);
    logic [NL-1:0] er = '0;
    for (int l = 0; l < NL; l++) begin
      lvl_sel = 3'(l);
      #1;
      chk(req, lvl_vec, exp_bits(l));
      er[l] = |exp_bits(l);
    end
    chk(req, NS'(level_req), NS'(er));
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
    if (a < 12) for (int k = 0; k < 8; k++) m_fld[a*8 + k] = d[k*4 +: 4];
    else if (a >= 16 && a < 19) for (int b = 0; b < 32; b++) m_en[(a-16)*32 + b] = d[b];
    @(negedge clk); // routed outputs reflect new config
  endtask

  task automatic rd_chk(input string req, input int a);
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = 5'(a);
    @(negedge clk);
    reg_ren = 1'b0;
    chk(req, NS'(reg_rdata), NS'(exp_word(a)));
  endtask

  task automatic drive(input logic [NS-1:0] v);
    @(negedge clk);
    src_irq = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int s = 0; s < NS; s++) begin
      m_fld[s] = (s == 19 || s == 20 || s == 94 || s == 95) ? 4'd5 : 4'hF;
      m_en[s]  = 1'b1;
    end
    cmp_all("R1 reset outputs");
    rd_chk("R1 word2", 2);
    rd_chk("R1 word11", 11);
    rd_chk("R1 word0", 0);
    rd_chk("R1 enable word", 17);
    chk("R1 word2 literal", NS'(exp_word(2)), NS'(32'hFFF5_5FFF));
  endtask

  task automatic t_default_route;
    logic [NS-1:0] v = '0;
    v[19] = 1'b1; v[95] = 1'b1;
    drive(v);
    chk("R3 default level 12", NS'(level_req), NS'(8'h20));
    cmp_all("R7 default bitset");
    drive('0);
    cmp_all("R4 release default");
  endtask

  task automatic t_latency;
    logic [NS-1:0] v = '0;
    v[20] = 1'b1;
    @(negedge clk);
    src_irq = v;
    #5;
    chk("R8 not before edge", NS'(level_req), '0);
    @(negedge clk);
    chk("R8 after one edge", NS'(level_req), NS'(8'h20));
    drive('0);
    chk("R8 drop", NS'(level_req), '0);
  endtask

  task automatic t_layout;
    wr(0, 32'h7654_3210);
    rd_chk("R2 readback word0", 0);
    for (int i = 0; i < 8; i++) begin
      logic [NS-1:0] v = '0;
      v[i] = 1'b1;
      drive(v);
      chk("R3 field value to level", NS'(level_req), NS'(8'(1) << i));
      cmp_all("R2 layout bitsets");
    end
    drive('0);
  endtask

  task automatic t_share;
    logic [NS-1:0] v = '0;
    wr(1, 32'hFFFF_FFF0); // source 8 joins source 0 on level 7
    v[0] = 1'b1; v[8] = 1'b1;
    drive(v);
    cmp_all("R4 two sharers");
    v[0] = 1'b0;
    drive(v);
    chk("R4 one sharer left", NS'(level_req[0]), NS'(1));
    cmp_all("R7 one sharer bitset");
    drive('0);
    cmp_all("R4 none left");
  endtask

  task automatic t_unrouted;
    logic [NS-1:0] v = '0;
    wr(0, 32'h7654_3218);
    v[0] = 1'b1;
    drive(v);
    chk("R5 field 8 silent", NS'(level_req), '0);
    rd_chk("R5 field 8 readback", 0);
    wr(0, 32'h7654_321F);
    cmp_all("R5 field F silent");
    drive('0);
  endtask

  task automatic t_mask;
    logic [NS-1:0] v = '0;
    wr(16, 32'hFFF7_FFFF); // clear enable bit 19
    v[19] = 1'b1;
    drive(v);
    chk("R6 masked no request", NS'(level_req), '0);
    cmp_all("R6 masked bitsets");
    rd_chk("R6 raw still visible", 20);
    wr(16, 32'hFFFF_FFFF);
    cmp_all("R6 unmasked routes");
    drive('0);
  endtask

  task automatic t_regmap;
    logic [NS-1:0] v = '0;
    logic [31:0] held;
    v[64] = 1'b1;
    drive(v);
    wr(22, 32'h0000_0000);
    rd_chk("R9 status not writable", 22);
    wr(30, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped reads zero", 30);
    rd_chk("R9 word1 untouched", 1);
    held = reg_rdata;
    @(negedge clk);
    reg_addr = 5'd11;
    @(negedge clk);
    chk("R10 rdata holds without read", NS'(reg_rdata), NS'(held));
    drive('0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_route();
    t_latency();
    t_layout();
    t_share();
    t_unrouted();
    t_mask();
    t_regmap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule